// File: doc/BRIEF.md
# Serial Converter Transaction Controller

This block is the host-side master for a 4-wire serial analog-to-digital converter. On a start command it lowers chip select, generates the I/O clock from a system-clock divider, shifts a 4-bit channel address out MSB first, and captures the 10-bit word that the converter returns. The returned word is the result of the conversion requested in the previous transaction, so the controller tags each result with the channel it belongs to. The first result after reset has no such request behind it and is marked stale.

Each transaction issues 10 to 16 I/O clocks. Chip select is either raised after every transaction (toggled operation) or kept low from the first transaction onward (continuous operation, where only 10 or 16 clocks are allowed). After the clocks, the controller waits for the converter's end-of-conversion line to go low and then high again. That line passes through a synchronizer first. Only then does it strobe the result and accept the next command. If the line never returns high, a timeout ends the wait and flags the result.

The controller is one state machine. IDLE waits for a start. SETUP lowers chip select and presents the first address bit. CLK_HIGH and CLK_LOW are the two phases of each I/O clock. WAIT_EOC waits for the converter. DONE strobes the result for one cycle. The transitions are:
- IDLE to SETUP on start.
- SETUP to CLK_HIGH, CLK_HIGH to CLK_LOW, and CLK_LOW back to CLK_HIGH, each when a phase ends.
- CLK_LOW to WAIT_EOC after the last clock.
- WAIT_EOC to DONE once end-of-conversion has been seen low and then high, or on timeout.
- DONE to IDLE.

Top module: `sadc_xfer_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, ioclk_o is 0, busy_o is 0, res_valid_o is 0 and timeout_o is 0.
- R2: start_i is accepted only in IDLE. busy_o is 1 from the cycle after acceptance through the result strobe. A start_i pulse while busy is ignored: it changes neither the channel sent nor the number of results.
- R3: The number of I/O clock rising edges per transaction depends on hold_cs_i and len_i. In toggled mode (hold_cs_i=0) it is len_i clamped to 10..16. In continuous mode (hold_cs_i=1) it is 10 when len_i is 10 or less, and 16 otherwise.
- R4: addr_o presents chan_i[3] before the first rising edge, then chan_i[2], chan_i[1] and chan_i[0] before the second, third and fourth rising edges. It changes only at falling edges, never while ioclk_o is high.
- R5: sdata_i is sampled at the first ten rising edges of ioclk_o. The first sample becomes result bit 9 and the tenth becomes bit 0. Samples taken after the tenth edge have no effect on the result.
- R6: Each ioclk_o high phase and low phase lasts CLK_DIV system clocks. A falling cs_n_o precedes the first rising edge by CLK_DIV system clocks.
- R7: In toggled mode, cs_n_o returns to 1 in the cycle after the result strobe. In continuous mode it stays 0. ioclk_o is never 1 while cs_n_o is 1.
- R8: After the last clock, no result is strobed until the synchronized end-of-conversion has been 0 at some point after the transfer began and is 1 again.
- R9: In transfers longer than 10 clocks, the eleventh rising edge follows the tenth falling edge within SLOW_BOUND system clocks.
- R10: res_chan_o carries the channel of the previous transaction. The first result after reset has res_stale_o=1 and res_chan_o=0. Every later result has res_stale_o=0.
- R11: If end-of-conversion does not complete within EOC_TIMEOUT system clocks of entering WAIT_EOC, the result is strobed with timeout_o=1. timeout_o then holds until the next accepted start.
- R12: res_valid_o is a single-cycle pulse. res_data_o, res_chan_o and res_stale_o hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in IDLE |
| chan_i | input | 4 | Channel address to send |
| len_i | input | 5 | Requested I/O clock count |
| hold_cs_i | input | 1 | 1 selects continuous chip-select operation |
| busy_o | output | 1 | Transaction in progress |
| cs_n_o | output | 1 | Chip select to converter, active low |
| ioclk_o | output | 1 | I/O clock to converter |
| addr_o | output | 1 | Serial address to converter |
| sdata_i | input | 1 | Serial data from converter |
| eoc_i | input | 1 | End-of-conversion from converter (asynchronous) |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 10 | Returned conversion word |
| res_chan_o | output | 4 | Channel the word belongs to |
| res_stale_o | output | 1 | Word has no prior request behind it |
| timeout_o | output | 1 | End-of-conversion wait timed out |

## Verification
Two situations are hard to reach from the ports. The first is continuous operation, where a new word appears without any chip-select edge. The converter model in the bench starts a new output sequence when it sees end-of-conversion rise. In a 16-clock transfer whose conversion finishes before the last clock, it starts the sequence at the sixteenth falling edge instead. The stimulus runs back-to-back continuous transactions with both 10 and 16 clocks, and the conversion time is chosen so that the 16-clock case finishes mid-transfer. The second is the timeout. For one transaction the model holds end-of-conversion low, and the bench then resets and checks that the stale flag comes back.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
    localparam int SADC_DATA_W = 10;
    localparam int SADC_CHAN_W = 4;
    localparam int SADC_LEN_W  = 5;
    localparam int SADC_MIN_CLKS = 10;
    localparam int SADC_MAX_CLKS = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_CLK_HIGH,
        S_CLK_LOW,
        S_WAIT_EOC,
        S_DONE
    } sadc_state_e;

    // Legal clock count for a request: continuous operation allows only
    // the short and the long count, toggled operation clamps to the range.
    function automatic logic [SADC_LEN_W-1:0] sadc_norm_len(
        input logic [SADC_LEN_W-1:0] req,
        input logic                  hold
    );
        if (hold)
            return (req > SADC_LEN_W'(SADC_MIN_CLKS)) ? SADC_LEN_W'(SADC_MAX_CLKS)
                                                       : SADC_LEN_W'(SADC_MIN_CLKS);
        if (req < SADC_LEN_W'(SADC_MIN_CLKS)) return SADC_LEN_W'(SADC_MIN_CLKS);
        if (req > SADC_LEN_W'(SADC_MAX_CLKS)) return SADC_LEN_W'(SADC_MAX_CLKS);
        return req;
    endfunction
endpackage

// File: rtl/sadc_sync.sv
`timescale 1ns/1ps
module sadc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sadc_phase_timer.sv
`timescale 1ns/1ps
module sadc_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sadc_shift.sv
`timescale 1ns/1ps
module sadc_shift #(
    parameter int AW = 4,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] chan,
    input  logic          fall,
    input  logic          sample,
    input  logic          sdata,
    output logic          addr_bit,
    output logic [DW-1:0] word
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            word_q <= '0;
        end else if (load) begin
            addr_q <= chan;
            word_q <= '0;
        end else begin
            if (fall)   addr_q <= {addr_q[AW-2:0], 1'b0};
            if (sample) word_q <= {word_q[DW-2:0], sdata};
        end
    end

    assign addr_bit = addr_q[AW-1];
    assign word     = word_q;
endmodule

// File: rtl/sadc_xfer_ctrl.sv
`timescale 1ns/1ps
module sadc_xfer_ctrl
    import sadc_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int SLOW_BOUND  = 16,
    parameter int EOC_TIMEOUT = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [SADC_CHAN_W-1:0] chan_i,
    input  logic [SADC_LEN_W-1:0]  len_i,
    input  logic                   hold_cs_i,
    output logic                   busy_o,
    output logic                   cs_n_o,
    output logic                   ioclk_o,
    output logic                   addr_o,
    input  logic                   sdata_i,
    input  logic                   eoc_i,
    output logic                   res_valid_o,
    output logic [SADC_DATA_W-1:0] res_data_o,
    output logic [SADC_CHAN_W-1:0] res_chan_o,
    output logic                   res_stale_o,
    output logic                   timeout_o
);
    localparam int TO_W  = $clog2(EOC_TIMEOUT + 1);
    localparam int GAP_W = $clog2(SLOW_BOUND + 1) + 1;

    sadc_state_e state_q, state_d;

    logic                   tick, run, rise_p, fall_p, accept, to_hit, eoc_ok;
    logic                   eoc_s, low_seen_q, hold_q, first_q, cs_n_q, to_q;
    logic [SADC_LEN_W-1:0]  rise_cnt_q, len_q;
    logic [SADC_CHAN_W-1:0] cur_chan_q, prev_chan_q, res_chan_q;
    logic [SADC_DATA_W-1:0] word, res_data_q;
    logic                   res_stale_q;
    logic [TO_W-1:0]        to_cnt_q;

    sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_eoc_sync (
        .clk(clk), .rst_n(rst_n), .d(eoc_i), .q(eoc_s)
    );

    assign run = (state_q == S_SETUP) || (state_q == S_CLK_HIGH) || (state_q == S_CLK_LOW);

    sadc_phase_timer #(.DIV(CLK_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    assign accept = (state_q == S_IDLE) && start_i;
    assign rise_p = tick && ((state_q == S_SETUP) ||
                             ((state_q == S_CLK_LOW) && (rise_cnt_q != len_q)));
    assign fall_p = tick && (state_q == S_CLK_HIGH);
    assign to_hit = (state_q == S_WAIT_EOC) && (to_cnt_q == TO_W'(EOC_TIMEOUT - 1));
    assign eoc_ok = low_seen_q && eoc_s;

    sadc_shift #(.AW(SADC_CHAN_W), .DW(SADC_DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .chan(chan_i),
        .fall(fall_p), .sample(rise_p && (rise_cnt_q < SADC_LEN_W'(SADC_DATA_W))),
        .sdata(sdata_i), .addr_bit(addr_o), .word(word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_SETUP;
            S_SETUP:    if (tick) state_d = S_CLK_HIGH;
            S_CLK_HIGH: if (tick) state_d = S_CLK_LOW;
            S_CLK_LOW:  if (tick) state_d = (rise_cnt_q == len_q) ? S_WAIT_EOC : S_CLK_HIGH;
            S_WAIT_EOC: if (eoc_ok || to_hit) state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transaction and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_chan_q  <= '0;
            prev_chan_q <= '0;
            len_q       <= SADC_LEN_W'(SADC_MIN_CLKS);
            hold_q      <= 1'b0;
            cs_n_q      <= 1'b1;
            rise_cnt_q  <= '0;
            low_seen_q  <= 1'b0;
            to_cnt_q    <= '0;
            to_q        <= 1'b0;
            first_q     <= 1'b1;
            res_data_q  <= '0;
            res_chan_q  <= '0;
            res_stale_q <= 1'b0;
        end else begin
            if (accept) begin
                cur_chan_q <= chan_i;
                len_q      <= sadc_norm_len(len_i, hold_cs_i);
                hold_q     <= hold_cs_i;
                cs_n_q     <= 1'b0;
                rise_cnt_q <= '0;
                low_seen_q <= 1'b0;
                to_q       <= 1'b0;
            end
            if (rise_p) rise_cnt_q <= rise_cnt_q + 1'b1;
            if (!eoc_s && (state_q == S_CLK_HIGH || state_q == S_CLK_LOW ||
                           state_q == S_WAIT_EOC))
                low_seen_q <= 1'b1;
            to_cnt_q <= (state_q == S_WAIT_EOC) ? to_cnt_q + 1'b1 : '0;
            if (state_q == S_WAIT_EOC && (eoc_ok || to_hit)) begin
                res_data_q  <= word;
                res_chan_q  <= prev_chan_q;
                res_stale_q <= first_q;
                to_q        <= !eoc_ok;
            end
            if (state_q == S_DONE) begin
                prev_chan_q <= cur_chan_q;
                first_q     <= 1'b0;
                if (!hold_q) cs_n_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        ioclk_o     = (state_q == S_CLK_HIGH);
        cs_n_o      = cs_n_q;
        res_valid_o = (state_q == S_DONE);
        res_data_o  = res_data_q;
        res_chan_o  = res_chan_q;
        res_stale_o = res_stale_q;
        timeout_o   = to_q;
    end

    // Checker counter: system clocks since the tenth falling edge
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else if (fall_p && rise_cnt_q == SADC_LEN_W'(SADC_DATA_W)) gap_q <= '0;
        else if (state_q == S_CLK_LOW && rise_cnt_q == SADC_LEN_W'(SADC_DATA_W) &&
                 gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + 1'b1;
    end

    a_r9_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && rise_cnt_q == SADC_LEN_W'(SADC_DATA_W)) |-> (gap_q < GAP_W'(SLOW_BOUND)));

    a_r7_clock_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ioclk_o |-> !cs_n_o);

    a_r4_addr_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ioclk_o && $past(ioclk_o)) |-> $stable(addr_o));

    a_r3_edge_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ioclk_o) |-> (rise_cnt_q <= len_q && len_q <= SADC_LEN_W'(SADC_MAX_CLKS)));

    a_r12_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    a_r2_chan_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cur_chan_q));

    a_r8_eoc_high_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !timeout_o) |-> $past(eoc_s));
endmodule

// File: tb/tb_sadc_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_sadc_xfer_ctrl;
    localparam int CLK_DIV = 4;
    localparam int SLOW_BOUND = 16;
    localparam int EOC_TIMEOUT = 300;
    localparam int CONV = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, hold_cs_i = 1'b0;
    logic [3:0] chan_i = '0;
    logic [4:0] len_i = 5'd10;
    logic busy_o, cs_n_o, ioclk_o, addr_o, sdata_i, res_valid_o, res_stale_o, timeout_o;
    logic [9:0] res_data_o;
    logic [3:0] res_chan_o;
    logic eoc = 1'b1;

    always #10 clk = ~clk;

    sadc_xfer_ctrl #(.CLK_DIV(CLK_DIV), .SLOW_BOUND(SLOW_BOUND), .EOC_TIMEOUT(EOC_TIMEOUT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .len_i(len_i),
        .hold_cs_i(hold_cs_i), .busy_o(busy_o), .cs_n_o(cs_n_o), .ioclk_o(ioclk_o),
        .addr_o(addr_o), .sdata_i(sdata_i), .eoc_i(eoc), .res_valid_o(res_valid_o),
        .res_data_o(res_data_o), .res_chan_o(res_chan_o), .res_stale_o(res_stale_o),
        .timeout_o(timeout_o)
    );

    int checks = 0, failures = 0;
    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] conv_of(input logic [3:0] a);
        return 10'h2A5 ^ {a, a[1:0], a};
    endfunction

    // Converter model
    int m_cnt = 0, m_ptr = 0, m_rise = 0, m_len = 10, rise_total = 0;
    logic [9:0] m_word = '0, m_latest = '0, m_pending = '0;
    logic [3:0] m_addr = '0;
    logic m_tail = 1'b0, m_stuck = 1'b0;
    time t_csf = 0, t_r1 = 0, t_f1 = 0, t_f10 = 0, t_r11 = 0;
    event conv_go;

    assign sdata_i = (m_ptr < 10) ? m_word[4'(9 - m_ptr)] : m_tail;

    task automatic new_seq();
        m_ptr = 0; m_cnt = 0; m_rise = 0; m_word = m_latest;
    endtask

    always @(negedge cs_n_o) begin t_csf = $time; new_seq(); end

    always @(posedge ioclk_o) begin
        m_rise++; rise_total++;
        if (m_rise <= 4) m_addr = {m_addr[2:0], addr_o};
        if (m_rise == 1) t_r1 = $time;
        if (m_rise == 11) t_r11 = $time;
    end

    always @(negedge ioclk_o) begin
        m_cnt++; m_ptr++;
        if (m_cnt == 1) t_f1 = $time;
        if (m_cnt == 10) begin
            t_f10 = $time; eoc = 1'b0; m_pending = conv_of(m_addr); -> conv_go;
        end
        if (m_cnt == m_len && eoc) new_seq();
    end

    initial forever begin
        @(conv_go);
        repeat (CONV) @(posedge clk);
        if (!m_stuck) begin
            m_latest = m_pending; eoc = 1'b1;
            if (!cs_n_o && m_cnt == m_len) new_seq();
        end
    end

    // Scoreboard
    typedef struct packed { logic [9:0] d; logic [3:0] c; logic s; logic t; } exp_t;
    exp_t exp_q[$];
    int done_cnt = 0;
    logic eoc_at_strobe;
    logic [3:0] prev_ch = '0;
    bit first = 1'b1;

    initial forever begin
        @(negedge clk);
        if (res_valid_o) begin
            exp_t e;
            logic [9:0] d;
            d = res_data_o;
            eoc_at_strobe = eoc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(res_data_o == e.d, "R5", "result data", int'(res_data_o), int'(e.d));
                check(res_chan_o == e.c, "R10", "result channel", int'(res_chan_o), int'(e.c));
                check(res_stale_o == e.s, "R10", "stale flag", int'(res_stale_o), int'(e.s));
                check(timeout_o == e.t, "R11", "timeout flag", int'(timeout_o), int'(e.t));
            end
            done_cnt++;
            @(negedge clk);
            check(!res_valid_o, "R12", "strobe width", int'(res_valid_o), 0);
            check(res_data_o == d, "R12", "data held", int'(res_data_o), int'(d));
        end
    end

    task automatic run_txn(input logic [3:0] ch, input logic [4:0] len, input logic hold,
                           input int exp_len, input bit inject, input bit stuck);
        int d0;
        exp_t e;
        while (busy_o) @(negedge clk);
        m_len = exp_len; rise_total = 0; m_stuck = stuck;
        e.d = first ? 10'h000 : conv_of(prev_ch);
        e.c = prev_ch; e.s = first; e.t = stuck;
        exp_q.push_back(e);
        d0 = done_cnt;
        chan_i = ch; len_i = len; hold_cs_i = hold; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R2", "busy after start", int'(busy_o), 1);
        if (inject) begin
            repeat (20) @(negedge clk);
            check(busy_o, "R2", "busy mid transfer", int'(busy_o), 1);
            chan_i = 4'hF; len_i = 5'd10; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (done_cnt != d0);
        check(rise_total == exp_len, "R3", "clock count", rise_total, exp_len);
        check(m_addr == ch, "R4", "address received", int'(m_addr), int'(ch));
        if (!stuck) check(eoc_at_strobe, "R8", "eoc high at strobe", int'(eoc_at_strobe), 1);
        @(negedge clk);
        check(cs_n_o == !hold, "R7", "chip select after strobe", int'(cs_n_o), int'(!hold));
        prev_ch = ch; first = 1'b0;
        if (inject) begin
            repeat (40) @(negedge clk);
            check(!busy_o && exp_q.size() == 0, "R2", "ignored start left no work",
                  int'(busy_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n_o && !ioclk_o && !busy_o && !res_valid_o && !timeout_o, "R1",
              "reset state", int'({cs_n_o, ioclk_o, busy_o, res_valid_o, timeout_o}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(4'd5, 5'd10, 1'b0, 10, 1'b0, 1'b0);
        check((t_r1 - t_csf) == CLK_DIV * 20, "R6", "cs fall to first rise ns",
              int'(t_r1 - t_csf), CLK_DIV * 20);
        check((t_f1 - t_r1) == CLK_DIV * 20, "R6", "high phase ns", int'(t_f1 - t_r1), CLK_DIV * 20);
        run_txn(4'd9, 5'd13, 1'b0, 13, 1'b0, 1'b0);
        check((t_r11 - t_f10) <= SLOW_BOUND * 20, "R9", "gap tenth fall to eleventh rise",
              int'(t_r11 - t_f10), SLOW_BOUND * 20);
        run_txn(4'd2, 5'd7, 1'b0, 10, 1'b0, 1'b0);
        m_tail = 1'b1;
        run_txn(4'd11, 5'd20, 1'b0, 16, 1'b0, 1'b0);
        m_tail = 1'b0;
        run_txn(4'd14, 5'd10, 1'b1, 10, 1'b0, 1'b0);
        run_txn(4'd3, 5'd12, 1'b1, 16, 1'b0, 1'b0);
        run_txn(4'd7, 5'd16, 1'b1, 16, 1'b0, 1'b0);
        run_txn(4'd1, 5'd14, 1'b0, 14, 1'b1, 1'b0);
        run_txn(4'd6, 5'd10, 1'b0, 10, 1'b0, 1'b0);
        run_txn(4'd8, 5'd10, 1'b0, 10, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        check(timeout_o, "R11", "timeout held", int'(timeout_o), 1);
        rst_n = 1'b0; m_stuck = 1'b0; eoc = 1'b1; m_latest = '0; first = 1'b1; prev_ch = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(4'd4, 5'd10, 1'b0, 10, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule